// File: doc/BRIEF.md
# Per-Channel Eye-Centring Bit Aligner

This block trains one channel of a source-synchronous receiver so that the sampling clock lands in the middle of the data-valid window. While the far end repeats a fixed training word, the block walks a 64-step input delay from its lowest setting upward. It does this by pulsing increment, decrement and clear controls of an external tap counter. At every step it lets the delay settle and then watches a few consecutive captured words. If those words disagree, the tap sits on a transition of the eye.

From the first unstable tap and the next unstable tap that follows a stable stretch, the block computes the centre of the eye. It then moves the delay there and raises a completion flag. The flag stays up until the next start request. The block only corrects skew smaller than one bit period; aligning words to the pattern boundary is left to later logic.

The delay line is modelled as a tap index that the block tracks itself and reports alongside the control pulses.

Top module: `eye_center_align`

## Requirements
- R1: While reset is low, and in the first cycle after it, done is 0, the three delay controls are 0 and tap_now is 0.
- R2: A start pulse sampled at any clock edge, in any state, restarts the search. dly_rst is high in the second cycle after the start cycle, tap_now is 0 in that cycle, and done is 0.
- R3: After each step of the search, no verdict is taken until SETTLE cycles have passed. Successive dly_inc pulses of the scan are at least SETTLE+NCMP cycles apart.
- R4: A tap counts as unstable when any two consecutive captured words differ over NCMP comparisons. The first edge is the lowest unstable tap. A run of adjacent unstable taps does not count as a second edge.
- R5: With a first edge e1 and a second edge e2 (the next unstable tap after at least one stable tap), the final tap is floor((e1+e2)/2).
- R6: If the scan reaches tap 63 with only one edge e1 found, the final tap is (e1+32) mod 64.
- R7: If no tap is unstable over the whole range, the final tap is 32.
- R8: The tap never wraps. dly_inc is never issued at tap 63, and dly_dec is never issued at tap 0.
- R9: Once done rises it stays high, with no delay-control pulses and an unchanging tap_now, until the next start.
- R10: The scan stops at the second edge: the highest tap reached equals e2, or 63 when fewer than two edges exist.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver word clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to (re)start training |
| rx_word | input | WORD_W | Parallel word captured at the current delay |
| dly_rst | output | 1 | Clear pulse for the delay tap counter |
| dly_inc | output | 1 | Increment pulse for the delay tap counter |
| dly_dec | output | 1 | Decrement pulse for the delay tap counter |
| tap_now | output | TAP_W | Tap index the delay line is set to |
| done | output | 1 | Delay parked at the eye centre |

## Verification
The bench aims at the search's corner cases:
- edges at the very first and very last taps;
- transition regions several taps wide;
- an odd edge sum, where the centre rounds down;
- a single edge near either end, where the offset wraps modulo 64;
- a fully clean range.

A design that mistook a wide transition region for two edges would park inside it. One that rounded the midpoint up, or failed to wrap the one-edge offset, would land one tap off or beyond the range. One that let the counter run past 63 would wrap to tap 0.

The bench also restarts a search halfway through. A design that kept stale edges across the restart would finish at the wrong tap. The bench further holds the finished state for a while, checking that no stray pulse moves the parked delay.

// File: rtl/eye_align_pkg.sv
// Shared types for the eye-centring bit aligner.
package eye_align_pkg;

    // Controller phases of a training run.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CLEAR,
        PH_MEASURE,
        PH_STEP,
        PH_PARK,
        PH_DONE
    } align_phase_e;

endpackage

// File: rtl/eye_tap_track.sv
// Tap tracker: turns step commands into registered pulses for the external
// delay tap counter and keeps a copy of the tap index.
// Assumes: at most one command is meaningful per cycle (clear wins, then
// increment). The tap saturates at both ends and never wraps.
module eye_tap_track #(
    parameter int NTAPS = 64,
    localparam int TAP_W = $clog2(NTAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_clr,
    input  logic             cmd_up,
    input  logic             cmd_down,
    output logic             dly_rst,
    output logic             dly_inc,
    output logic             dly_dec,
    output logic [TAP_W-1:0] tap
);

    localparam logic [TAP_W-1:0] TAP_TOP = TAP_W'(NTAPS - 1);

    logic at_top;
    logic at_bot;
    logic go_up;
    logic go_down;

    // Decide which command is accepted this cycle, with saturation.
    always_comb begin
        at_top  = (tap == TAP_TOP);
        at_bot  = (tap == '0);
        go_up   = cmd_up && !cmd_clr && !at_top;
        go_down = cmd_down && !cmd_clr && !cmd_up && !at_bot;
    end

    // Register the control pulses and update the tracked tap in step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_rst <= 1'b0;
            dly_inc <= 1'b0;
            dly_dec <= 1'b0;
            tap     <= '0;
        end else begin
            dly_rst <= cmd_clr;
            dly_inc <= go_up;
            dly_dec <= go_down;
            if (cmd_clr) begin
                tap <= '0;
            end else if (go_up) begin
                tap <= tap + 1'b1;
            end else if (go_down) begin
                tap <= tap - 1'b1;
            end
        end
    end

    // R8: the top tap never steps over to the bottom.
    a_r8_no_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
        (tap == TAP_TOP && !cmd_clr) |=> (tap != '0));

    // R8: the bottom tap never steps under to the top.
    a_r8_no_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
        (tap == '0 && !cmd_clr) |=> (tap != TAP_TOP));

    // R8: at most one control pulse leaves the block per cycle.
    a_r8_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dly_rst, dly_inc, dly_dec}));

endmodule

// File: rtl/eye_edge_probe.sv
// Edge probe: after a launch it waits SETTLE cycles for the delay to settle.
// It then compares NCMP pairs of consecutive words and reports, in a single
// verdict pulse, whether any pair disagreed.
// Assumes: the training word repeats every cycle, so a stable tap captures
// the same word each cycle. A new launch abandons any probe in progress.
module eye_edge_probe #(
    parameter int WORD_W = 8,
    parameter int SETTLE = 4,
    parameter int NCMP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [WORD_W-1:0] rx_word,
    output logic              verdict_vld,
    output logic              verdict_unst
);

    localparam int TOTAL = SETTLE + NCMP;
    localparam int CW    = $clog2(TOTAL + 1);
    localparam logic [CW-1:0] LOAD = CW'(TOTAL);
    localparam logic [CW-1:0] WIN  = CW'(NCMP);

    logic [CW-1:0]     cnt;
    logic [WORD_W-1:0] prev_word;
    logic              unst_acc;
    logic              in_win;
    logic              mism;

    // Flag the comparison window and a mismatch in this cycle.
    always_comb begin
        in_win = (cnt != '0) && (cnt <= WIN);
        mism   = (rx_word != prev_word);
    end

    // Run the settle countdown, accumulate mismatches and emit the verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt          <= '0;
            prev_word    <= '0;
            unst_acc     <= 1'b0;
            verdict_vld  <= 1'b0;
            verdict_unst <= 1'b0;
        end else begin
            prev_word   <= rx_word;
            verdict_vld <= 1'b0;
            if (launch) begin
                cnt      <= LOAD;
                unst_acc <= 1'b0;
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
                if (in_win) begin
                    unst_acc <= unst_acc | mism;
                end
                if (cnt == CW'(1)) begin
                    verdict_vld  <= 1'b1;
                    verdict_unst <= unst_acc | mism;
                end
            end
        end
    end

    // R3: no verdict appears in the cycle right after a launch.
    a_r3_settle_first: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !verdict_vld);

    // R4: a verdict is a single-cycle pulse.
    a_r4_single_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_vld |=> !verdict_vld);

endmodule

// File: rtl/eye_align_ctrl.sv
// Training controller. It clears the delay and scans upward one tap at a time,
// letting the probe judge every tap. It records the first unstable tap and the
// next unstable tap after a stable stretch, picks the centre tap and walks the
// delay there.
// Assumes: NTAPS is a power of two, so the one-edge offset wraps naturally.
module eye_align_ctrl
    import eye_align_pkg::*;
#(
    parameter int NTAPS = 64,
    localparam int TAP_W = $clog2(NTAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             verdict_vld,
    input  logic             verdict_unst,
    input  logic [TAP_W-1:0] tap,
    output logic             cmd_clr,
    output logic             cmd_up,
    output logic             cmd_down,
    output logic             probe_go,
    output logic             done
);

    localparam logic [TAP_W-1:0] TAP_TOP = TAP_W'(NTAPS - 1);
    localparam logic [TAP_W-1:0] HALF    = TAP_W'(NTAPS / 2);

    align_phase_e     phase;
    logic             have_e1;
    logic             seen_gap;
    logic [TAP_W-1:0] e1;
    logic [TAP_W-1:0] target;
    logic [TAP_W:0]   edge_sum;
    logic [TAP_W-1:0] one_edge;
    logic [TAP_W-1:0] lone_target;

    // Work out the centre tap for the two-edge and the one-or-no-edge cases.
    always_comb begin
        edge_sum    = {1'b0, e1} + {1'b0, tap};
        one_edge    = have_e1 ? e1 : tap;
        lone_target = (have_e1 || verdict_unst) ? (one_edge + HALF) : HALF;
    end

    // Drive the delay commands and the probe launch from the phase.
    always_comb begin
        cmd_clr  = (phase == PH_CLEAR);
        probe_go = (phase == PH_CLEAR) || (phase == PH_STEP);
        cmd_up   = (phase == PH_STEP) || ((phase == PH_PARK) && (tap < target));
        cmd_down = (phase == PH_PARK) && (tap > target);
        done     = (phase == PH_DONE);
    end

    // Sequence the run and record the edges from each verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            have_e1  <= 1'b0;
            seen_gap <= 1'b0;
            e1       <= '0;
            target   <= '0;
        end else if (start) begin
            phase <= PH_CLEAR;
        end else begin
            case (phase)
                PH_IDLE: phase <= PH_IDLE;
                PH_CLEAR: begin
                    have_e1  <= 1'b0;
                    seen_gap <= 1'b0;
                    phase    <= PH_MEASURE;
                end
                PH_MEASURE: begin
                    if (verdict_vld) begin
                        if (verdict_unst && have_e1 && seen_gap) begin
                            target <= edge_sum[TAP_W:1];
                            phase  <= PH_PARK;
                        end else if (tap == TAP_TOP) begin
                            target <= lone_target;
                            phase  <= PH_PARK;
                        end else begin
                            if (verdict_unst && !have_e1) begin
                                e1      <= tap;
                                have_e1 <= 1'b1;
                            end
                            if (!verdict_unst && have_e1) begin
                                seen_gap <= 1'b1;
                            end
                            phase <= PH_STEP;
                        end
                    end
                end
                PH_STEP: phase <= PH_MEASURE;
                PH_PARK: begin
                    if (tap == target) begin
                        phase <= PH_DONE;
                    end
                end
                PH_DONE: phase <= PH_DONE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R9: the finished state holds until a start arrives.
    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R10: a run that is parking never launches another probe.
    a_r10_no_probe_park: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PARK) |-> !probe_go);

endmodule

// File: rtl/eye_center_align.sv
// Top of the eye-centring bit aligner for one receive channel. It ties the
// controller, the edge probe and the tap tracker together.
// Assumes: rx_word comes from the channel's capture register at the delay
// set by the dly_* pulses, and the training word repeats every cycle.
module eye_center_align
    import eye_align_pkg::*;
#(
    parameter int NTAPS  = 64,
    parameter int WORD_W = 8,
    parameter int SETTLE = 4,
    parameter int NCMP   = 4,
    localparam int TAP_W = $clog2(NTAPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] rx_word,
    output logic              dly_rst,
    output logic              dly_inc,
    output logic              dly_dec,
    output logic [TAP_W-1:0]  tap_now,
    output logic              done
);

    logic cmd_clr;
    logic cmd_up;
    logic cmd_down;
    logic probe_go;
    logic verdict_vld;
    logic verdict_unst;

    eye_align_ctrl #(.NTAPS(NTAPS)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .verdict_vld  (verdict_vld),
        .verdict_unst (verdict_unst),
        .tap          (tap_now),
        .cmd_clr      (cmd_clr),
        .cmd_up       (cmd_up),
        .cmd_down     (cmd_down),
        .probe_go     (probe_go),
        .done         (done)
    );

    eye_edge_probe #(.WORD_W(WORD_W), .SETTLE(SETTLE), .NCMP(NCMP)) u_probe (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch       (probe_go),
        .rx_word      (rx_word),
        .verdict_vld  (verdict_vld),
        .verdict_unst (verdict_unst)
    );

    eye_tap_track #(.NTAPS(NTAPS)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_clr  (cmd_clr),
        .cmd_up   (cmd_up),
        .cmd_down (cmd_down),
        .dly_rst  (dly_rst),
        .dly_inc  (dly_inc),
        .dly_dec  (dly_dec),
        .tap      (tap_now)
    );

    // R2: a start produces the clear pulse two cycles later.
    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ##2 dly_rst);

    // R9: while finished, the parked delay receives no step pulse.
    a_r9_parked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!dly_inc && !dly_dec));

    // R9: the tap holds still across cycles spent finished.
    a_r9_parked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> $stable(tap_now));

endmodule

// File: tb/sim_eye_center_align.sv
`timescale 1ns/1ps
module sim_eye_center_align;

    localparam int NTAPS  = 64;
    localparam int WORD_W = 8;
    localparam int SETTLE = 4;
    localparam int NCMP   = 4;
    localparam logic [WORD_W-1:0] PAT = 8'hB4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [WORD_W-1:0] rx_word = PAT;
    logic              dly_rst;
    logic              dly_inc;
    logic              dly_dec;
    logic [5:0]        tap_now;
    logic              done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Delay line model and scoreboard state.
    logic [63:0] mask = '0;
    int  mtap = 0;
    int  mtap_max = 0;
    bit  ph = 1'b0;
    int  since_inc = 1000;
    int  min_gap = 1000;
    int  pulse_cnt = 0;
    bit  done_q = 1'b0;
    int  exp_q[$];

    always #2.5 clk = ~clk;

    eye_center_align #(.NTAPS(NTAPS), .WORD_W(WORD_W), .SETTLE(SETTLE), .NCMP(NCMP)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .rx_word (rx_word),
        .dly_rst (dly_rst),
        .dly_inc (dly_inc),
        .dly_dec (dly_dec),
        .tap_now (tap_now),
        .done    (done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp,
                       input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Model the delay line, drive the captured word and run the monitor.
    always @(negedge clk) begin
        cycles++;
        since_inc++;
        if (dly_inc || dly_dec || dly_rst) pulse_cnt++;
        if (dly_rst) begin
            mtap = 0;
        end else if (dly_inc) begin
            if (since_inc < min_gap) min_gap = since_inc;
            since_inc = 0;
            if (mtap == 63) chk(1'b0, "R8", mtap + 1, 63, "increment at top tap");
            else mtap++;
        end else if (dly_dec) begin
            if (mtap == 0) chk(1'b0, "R8", -1, 0, "decrement at bottom tap");
            else mtap--;
        end
        if (mtap > mtap_max) mtap_max = mtap;
        if (mask[mtap]) ph = ~ph;
        else ph = 1'b0;
        rx_word = ph ? ~PAT : PAT;
        if (done && !done_q && exp_q.size() > 0) begin
            int e;
            e = exp_q.pop_front();
            chk(int'(tap_now) == e, "R5/R6/R7", int'(tap_now), e, "final tap_now");
            chk(mtap == e, "R5/R6/R7", mtap, e, "delay line model tap");
        end
        done_q = done;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL WDOG watchdog expired actual=%0d expected=%0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Pulse start and check the clear pulse (R2).
    task automatic kick(input string tag);
        @(posedge clk); #1;
        start = 1'b1;
        mtap_max = 0;
        min_gap = 1000;
        since_inc = 1000;
        @(posedge clk); #1;
        start = 1'b0;
        @(posedge clk); #1;
        chk(dly_rst == 1'b1, "R2", int'(dly_rst), 1, {tag, " clear pulse"});
        chk(tap_now == 6'd0, "R2", int'(tap_now), 0, {tag, " tap after clear"});
        chk(done == 1'b0, "R2", int'(done), 0, {tag, " done dropped"});
    endtask

    task automatic run_case(input logic [63:0] m, input int exp, input int exp_max,
                            input string tag, input string req);
        int t;
        mask = m;
        kick(tag);
        exp_q.push_back(exp);
        t = 0;
        while (exp_q.size() != 0 && t < 5000) begin
            @(posedge clk);
            t++;
        end
        #1;
        chk(exp_q.size() == 0, req, t, 0, {tag, " finished in time"});
        chk(mtap_max == exp_max, "R10", mtap_max, exp_max, {tag, " highest tap reached"});
        chk(min_gap >= SETTLE + NCMP, "R3", min_gap, SETTLE + NCMP, {tag, " scan step spacing"});
    endtask

    initial begin
        int held;
        // R1: reset state.
        repeat (3) @(posedge clk);
        #1;
        chk(done == 1'b0, "R1", int'(done), 0, "done in reset");
        chk({dly_rst, dly_inc, dly_dec} == 3'b000, "R1", int'({dly_rst, dly_inc, dly_dec}), 0,
            "pulses in reset");
        chk(tap_now == 6'd0, "R1", int'(tap_now), 0, "tap in reset");
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(done == 1'b0 && tap_now == 6'd0, "R1", int'(done), 0, "first cycle after reset");

        // R5: two clean edges.
        run_case(64'd1 << 10 | 64'd1 << 40, 25, 40, "edges 10/40", "R5");
        // R9: done sticky, delay quiet while parked.
        held = int'(tap_now);
        pulse_cnt = 0;
        repeat (40) @(posedge clk);
        #1;
        chk(done == 1'b1, "R9", int'(done), 1, "done held");
        chk(int'(tap_now) == held, "R9", int'(tap_now), held, "tap held");
        chk(pulse_cnt == 0, "R9", pulse_cnt, 0, "no pulses while done");

        // R4: wide transition regions count as one edge each.
        run_case(64'h001C_0000_0000_00E0, 27, 50, "wide regions", "R4");
        // R5: odd sum rounds down.
        run_case(64'd1 << 11 | 64'd1 << 40, 25, 40, "edges 11/40", "R5");
        // R5: edges at both ends of the range.
        run_case(64'd1 | 64'd1 << 63, 31, 63, "edges 0/63", "R5");
        // R6: single edge, no wrap of the offset.
        run_case(64'd1 << 20, 52, 63, "single 20", "R6");
        // R6: single edge, offset wraps modulo 64; R8 saturation at the top.
        run_case(64'd1 << 45, 13, 63, "single 45", "R6");
        // R7: clean range.
        run_case(64'd0, 32, 63, "no edge", "R7");

        // R2: restart in the middle of a search.
        mask = 64'd1 << 30;
        kick("restart first");
        repeat (150) @(posedge clk);
        #1;
        chk(done == 1'b0, "R2", int'(done), 0, "mid search still busy");
        run_case(64'd1 << 10 | 64'd1 << 40, 25, 40, "restart second", "R2");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule